// File: doc/BRIEF.md
# Local Bus Use Priority Arbiter

This block chooses which requester owns the next cycle on a processor's local bus. It can also hand the whole bus to an outside master. Six internal sources can ask for a cycle:

- a locked transfer sequence
- the second half of a word split at an odd address
- the continuation cycles of a coprocessor operand move
- the opening cycle of such a move
- execution-unit data traffic
- instruction prefetch

An external hold pin is the seventh contender. It ranks below the continuation cycles and above all new internal traffic.

Ownership changes only at a bus-cycle boundary, which the `cycle_done` input marks, so a cycle in flight is never cut short. When hold wins, the bus parks in a hold state. The block then floats the address and cycle-type outputs and returns a hold acknowledge one clock later. When the outside master lets go, the bus passes through idle before any internal grant. A hold request is ignored for a fixed window after reset while a saturating counter runs.

Top module: `bus_use_arbiter`

## Requirements
- R1: `grant` is zero or one-hot. Once a requester owns the bus, `grant` and `bus_state` do not change while `cycle_done` is low.
- R2: At a boundary (`bus_state` idle, or owned with `cycle_done` high), the winner is the highest pending level in this order: lock, split, coprocessor continuation, hold, coprocessor first cycle, execution unit, prefetch. Grant bits are [0] lock, [1] split, [2] continuation, [3] first cycle, [4] execution unit, [5] prefetch.
- R3: Prefetch (`grant` bit 5) is granted only when no other request, hold included once valid, is pending at that boundary.
- R4: When hold wins, `bus_state` becomes 2'b10 on the next clock and `grant` is all zero for as long as the hold lasts. Idle is 2'b00 and owned is 2'b01.
- R5: `float_addr` and `float_cyc` are high whenever `bus_state` is 2'b10 or `hold_ack` is high, and low otherwise.
- R6: After `rst_n` rises, `hold_req` is ignored for 34 clocks. The first rising edge that can move the bus to hold is the 35th.
- R7: `hold_ack` rises one clock after `bus_state` becomes 2'b10. When `hold_req` falls, `bus_state` goes to 2'b00 on the next clock and `hold_ack` falls one clock after that. A pending request is granted one clock after the idle state.
- R8: An owner holding the lock (bit 0) or split (bit 1) grant keeps it across boundaries while its request stays high, even against a higher request or a valid hold.
- R9: At an owned boundary with nothing pending, `bus_state` returns to 2'b00 and `grant` to zero. The reset state is idle, zero grant, no acknowledge and no float.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cycle_done | input | 1 | Current bus cycle ends on this clock |
| req_lock | input | 1 | Locked transfer request |
| req_split | input | 1 | Second half of odd-address word request |
| req_cop_next | input | 1 | Coprocessor continuation cycle request |
| hold_req | input | 1 | External master hold request |
| req_cop_first | input | 1 | Coprocessor first-cycle request |
| req_exec | input | 1 | Execution-unit data request |
| req_fetch | input | 1 | Instruction prefetch request |
| grant | output | 6 | One-hot grant, bit order as in R2 |
| bus_state | output | 2 | 00 idle, 01 owned, 10 hold |
| hold_ack | output | 1 | Hold acknowledge |
| float_addr | output | 1 | Float address drivers |
| float_cyc | output | 1 | Float memory/IO and code/acknowledge drivers |

## Verification
The bench sweeps all 128 patterns of the seven request lines from idle. If the priority is ranked wrong, it reports the wrong grant bit. If hold is mishandled, it reports a nonzero grant in hold or a missing acknowledge. It counts the edges of the reset window one by one, so a counter that is one short or one long exposes hold a clock early or late. Separate sequences raise a higher request in the middle of a cycle and raise hold against a split owner. A preempting design would switch owners before `cycle_done`, and one without stickiness would drop the split. A release check catches a design that grants straight out of hold without passing through idle.

// File: rtl/bua_pkg.sv
package bua_pkg;
  typedef enum logic [1:0] {
    BS_IDLE = 2'b00,
    BS_OWN  = 2'b01,
    BS_HOLD = 2'b10
  } bus_state_e;

  localparam int NLVL    = 7;
  localparam int NGNT    = 6;
  localparam int LV_LOCK = 0;
  localparam int LV_SPLT = 1;
  localparam int LV_CNXT = 2;
  localparam int LV_HOLD = 3;
  localparam int LV_CFST = 4;
  localparam int LV_EXEC = 5;
  localparam int LV_FTCH = 6;

  localparam int G_LOCK  = 0;
  localparam int G_SPLT  = 1;
endpackage

// File: rtl/bua_hold_window.sv
module bua_hold_window #(
  parameter int LIMIT = 34,
  localparam int W    = $clog2(LIMIT + 1)
) (
  input  logic clk,
  input  logic rst_n,
  output logic open_o
);
  logic [W-1:0] cnt_q, cnt_n;
  logic         cnt_en;

  assign cnt_en = (cnt_q != W'(LIMIT));

  always_comb begin
    cnt_n = cnt_q + W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_n;
  end

  assign open_o = ~cnt_en;

  a_r6_saturate: assert property (@(posedge clk) disable iff (!rst_n)
    open_o |=> open_o);
endmodule

// File: rtl/bua_prio_pick.sv
module bua_prio_pick #(
  parameter int N = 7
) (
  input  logic [N-1:0] req_i,
  output logic [N-1:0] pick_o
);
  logic [N-1:0] above;

  assign above[0] = 1'b0;
  genvar i;
  generate
    for (i = 1; i < N; i++) begin : g_chain
      assign above[i] = above[i-1] | req_i[i-1];
    end
    for (i = 0; i < N; i++) begin : g_pick
      assign pick_o[i] = req_i[i] & ~above[i];
    end
  endgenerate

  always_comb begin
    a_r2_pick_onehot: assert ($onehot0(pick_o));
    a_r2_pick_any: assert ((|pick_o) == (|req_i));
  end
endmodule

// File: rtl/bua_bus_fsm.sv
module bua_bus_fsm
  import bua_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cycle_done,
  input  logic            hold_req,
  input  logic            keep_lock,
  input  logic            keep_split,
  input  logic [NLVL-1:0] pick,
  output logic [NGNT-1:0] grant,
  output bus_state_e      state,
  output logic            hold_ack
);
  bus_state_e      st_q, st_n;
  logic [NGNT-1:0] gnt_q, gnt_n, gnt_pick;
  logic            ack_q;
  logic            boundary, sticky;

  genvar g;
  generate
    for (g = 0; g < NGNT; g++) begin : g_map
      localparam int LV = (g < LV_HOLD) ? g : g + 1;
      assign gnt_pick[g] = pick[LV];
    end
  endgenerate

  assign sticky   = (gnt_q[G_LOCK] & keep_lock) | (gnt_q[G_SPLT] & keep_split);
  assign boundary = (st_q == BS_IDLE) || (st_q == BS_HOLD) ||
                    ((st_q == BS_OWN) && cycle_done && !sticky);

  always_comb begin
    st_n  = st_q;
    gnt_n = gnt_q;
    unique case (st_q)
      BS_HOLD: begin
        if (!hold_req) st_n = BS_IDLE;
        gnt_n = '0;
      end
      default: begin
        if (pick[LV_HOLD]) begin
          st_n  = BS_HOLD;
          gnt_n = '0;
        end else if (|gnt_pick) begin
          st_n  = BS_OWN;
          gnt_n = gnt_pick;
        end else begin
          st_n  = BS_IDLE;
          gnt_n = '0;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= BS_IDLE;
      gnt_q <= '0;
    end else if (boundary) begin
      st_q  <= st_n;
      gnt_q <= gnt_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ack_q <= 1'b0;
    else        ack_q <= (st_q == BS_HOLD);
  end

  assign grant    = gnt_q;
  assign state    = st_q;
  assign hold_ack = ack_q;

  a_r1_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));
  a_r1_no_preempt: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == BS_OWN && !cycle_done) |=> ($stable(grant) && st_q == BS_OWN));
  a_r4_hold_no_grant: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == BS_HOLD) |-> (grant == '0));
  a_r7_ack_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == BS_HOLD) |=> hold_ack);
  a_r7_idle_after_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == BS_HOLD && !hold_req) |=> (st_q == BS_IDLE && grant == '0));
  a_r8_keep_lock: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == BS_OWN && grant[G_LOCK] && keep_lock) |=> grant[G_LOCK]);
  a_r8_keep_split: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == BS_OWN && grant[G_SPLT] && keep_split) |=> grant[G_SPLT]);
endmodule

// File: rtl/bus_use_arbiter.sv
module bus_use_arbiter
  import bua_pkg::*;
#(
  parameter int HOLD_BLOCK = 34
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cycle_done,
  input  logic       req_lock,
  input  logic       req_split,
  input  logic       req_cop_next,
  input  logic       hold_req,
  input  logic       req_cop_first,
  input  logic       req_exec,
  input  logic       req_fetch,
  output logic [5:0] grant,
  output logic [1:0] bus_state,
  output logic       hold_ack,
  output logic       float_addr,
  output logic       float_cyc
);
  logic            win_open;
  logic [NLVL-1:0] req_vec, pick;
  bus_state_e      st;

  bua_hold_window #(.LIMIT(HOLD_BLOCK)) u_win (
    .clk(clk), .rst_n(rst_n), .open_o(win_open)
  );

  always_comb begin
    req_vec          = '0;
    req_vec[LV_LOCK] = req_lock;
    req_vec[LV_SPLT] = req_split;
    req_vec[LV_CNXT] = req_cop_next;
    req_vec[LV_HOLD] = hold_req & win_open;
    req_vec[LV_CFST] = req_cop_first;
    req_vec[LV_EXEC] = req_exec;
    req_vec[LV_FTCH] = req_fetch;
  end

  bua_prio_pick #(.N(NLVL)) u_pick (.req_i(req_vec), .pick_o(pick));

  bua_bus_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .cycle_done(cycle_done), .hold_req(hold_req),
    .keep_lock(req_lock), .keep_split(req_split), .pick(pick),
    .grant(grant), .state(st), .hold_ack(hold_ack)
  );

  assign bus_state  = st;
  assign float_addr = (st == BS_HOLD) | hold_ack;
  assign float_cyc  = (st == BS_HOLD) | hold_ack;

  a_r5_float_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_state == 2'b10) |-> (float_addr && float_cyc));
  a_r6_window: assert property (@(posedge clk) disable iff (!rst_n)
    (!win_open && bus_state != 2'b10) |=> (bus_state != 2'b10));
  a_r3_fetch_alone: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_state != 2'b01 && req_fetch && (req_lock || req_split || req_cop_next ||
     req_cop_first || req_exec)) |=> !grant[5]);
endmodule

// File: tb/sim_bus_use_arbiter.sv
module sim_bus_use_arbiter;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cycle_done = 1'b1;
  logic req_lock = 0, req_split = 0, req_cop_next = 0, hold_req = 0;
  logic req_cop_first = 0, req_exec = 0, req_fetch = 0;
  logic [5:0] grant;
  logic [1:0] bus_state;
  logic hold_ack, float_addr, float_cyc;
  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  bus_use_arbiter u0 (.*);

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic set_req(input logic [6:0] p);
    {req_fetch, req_exec, req_cop_first, hold_req, req_cop_next, req_split, req_lock} = p;
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic check_state(input string tag, input logic [1:0] s, input logic [5:0] g);
    chk(bus_state == s, {tag, " state"}, bus_state, s);
    chk(grant == g, {tag, " grant"}, grant, g);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [5:0] eg;
    logic [1:0] es;
    int top;
    tick();
    // R9: reset state
    check_state("R9 reset", 2'b00, 6'd0);
    chk(!hold_ack && !float_addr && !float_cyc, "R9 reset ack/float", hold_ack, 0);
    // R6: hold blocked for 34 clocks
    hold_req = 1; req_fetch = 1; cycle_done = 1;
    rst_n = 1;
    for (int k = 1; k <= 34; k++) begin
      tick();
      if (k == 1 || k == 34) check_state("R6 window", 2'b01, 6'b100000);
    end
    tick();
    check_state("R6 hold at 35", 2'b10, 6'd0);
    tick();
    chk(hold_ack == 1, "R7 ack", hold_ack, 1);
    chk(float_addr && float_cyc, "R5 float", float_addr, 1);
    // R7: release path
    req_fetch = 0; req_exec = 1; hold_req = 0;
    tick();
    check_state("R7 idle first", 2'b00, 6'd0);
    chk(hold_ack == 1, "R7 ack lingers", hold_ack, 1);
    chk(float_addr == 1, "R5 float lingers", float_addr, 1);
    tick();
    check_state("R7 grant after idle", 2'b01, 6'b010000);
    chk(hold_ack == 0 && float_addr == 0 && float_cyc == 0, "R7 ack drop / R5", hold_ack, 0);
    set_req(7'd0); tick(); tick();
    // R2/R3/R4: exhaustive sweep from idle
    for (int p = 0; p < 128; p++) begin
      top = -1;
      for (int b = 6; b >= 0; b--) if (p[b]) top = b;
      if (top < 0)       begin es = 2'b00; eg = 6'd0; end
      else if (top == 3) begin es = 2'b10; eg = 6'd0; end
      else begin es = 2'b01; eg = 6'd1 << ((top < 3) ? top : top - 1); end
      set_req(7'(p));
      tick();
      check_state(top == 6 ? "R3 fetch sweep" : (top == 3 ? "R4 hold sweep" : "R2 sweep"), es, eg);
      set_req(7'd0);
      tick();
      if (top == 3) chk(hold_ack == 1, "R7 sweep ack", hold_ack, 1);
      else check_state("R9 back to idle", 2'b00, 6'd0);
      tick(); tick();
    end
    // R1: no preemption mid-cycle
    req_exec = 1; cycle_done = 0;
    tick();
    check_state("R1 exec owns", 2'b01, 6'b010000);
    req_lock = 1;
    tick(); tick(); tick();
    check_state("R1 no preempt", 2'b01, 6'b010000);
    cycle_done = 1;
    tick();
    check_state("R1 boundary switch", 2'b01, 6'b000001);
    set_req(7'd0); tick(); tick();
    // R8: split sticky against lock and hold
    req_split = 1;
    tick();
    check_state("R8 split owns", 2'b01, 6'b000010);
    req_lock = 1; hold_req = 1;
    tick(); tick(); tick();
    check_state("R8 split kept", 2'b01, 6'b000010);
    req_split = 0;
    tick();
    check_state("R8 lock next", 2'b01, 6'b000001);
    req_lock = 0;
    tick();
    check_state("R4 hold after lock", 2'b10, 6'd0);
    hold_req = 0; tick(); tick(); tick();
    check_state("R9 final idle", 2'b00, 6'd0);
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule